// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory with a 36-bit data path. The path is split into four 9-bit byte lanes. It accepts a read or a write on every enabled clock. Any mix of reads and writes can run back to back with no idle cycles between them. Write data arrives late, on the same pipeline slot where read data would leave. To allow this, the write address and control travel down a two-stage command pipeline until their data shows up. A read that follows a write to the same address, before that write has reached the array, is served from the incoming data. The incoming lanes are merged over the stored word.

Each cycle either loads a new address or continues a four-beat burst from the last loaded address. Bursts use wrapping linear order or XOR order. The cycle's direction is taken from the load cycle. A clock enable freezes the whole pipeline. Three chip-select inputs of mixed polarity qualify each load. An asynchronous output enable gates the read drive. A sleep input stops all traffic. After sleep ends, writes stay blocked for a programmable number of enabled cycles while reads are still allowed.

Top module: `pipe_sram`

## Requirements
- R1: A read captured at enabled edge k drives its word on `dq_o` with `dq_drv` high after enabled edge k+1, ready to be sampled at enabled edge k+2.
- R2: A write captured at enabled edge k samples `dq_i` at enabled edge k+2. Reads and writes may alternate on consecutive cycles with no idle cycle.
- R3: Lane i is `dq` bits 9i+8..9i. Lane i is written only when `lane_we_n[i]` is 0 on the write's address cycle. The other lanes keep their stored contents.
- R4: A read captured one enabled cycle after a write to the same address returns the written lanes of that write, merged over the stored word.
- R5: `dq_drv` is high only while a read result is held and `oe_n` is 0. `oe_n` acts without a clock. The output is never driven in the cycle that carries a write's data.
- R6: While `clk_en` is 0, no command is accepted, the pipeline does not advance, and `dq_o`/`dq_drv` hold their values.
- R7: A load cycle selects the device only when `chip_en1_n`=0, `chip_en2`=1 and `chip_en3_n`=0. Otherwise the cycle is a deselect: nothing is written and nothing is driven.
- R8: With `ld_n`=1 the cycle continues the burst. It uses the direction and chip selection of the last load and ignores `addr` and `we_n`. Beat n (n=1,2,3, wrapping) puts base+n modulo 4 in the two low address bits when `burst_il`=0, and base XOR n when `burst_il`=1. The upper address bits keep the base.
- R9: While `sleep` is 1, every cycle is a deselect and `dq_drv` is 0.
- R10: For the first `WAKE_CYC` enabled cycles after `sleep` falls, writes are discarded while reads are served.
- R11: After reset, `dq_drv` is 0 and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock qualifier; 0 freezes the block |
| chip_en1_n | input | 1 | Chip select, active low |
| chip_en2 | input | 1 | Chip select, active high |
| chip_en3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read, on load cycles |
| lane_we_n | input | 4 | Per-lane write select, active low |
| ld_n | input | 1 | 0 = load new address, 1 = continue burst |
| burst_il | input | 1 | Burst order: 0 linear, 1 XOR |
| addr | input | ADDR_W | Word address |
| sleep | input | 1 | Low-power request |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 36 | Write data |
| dq_o | output | 36 | Read data |
| dq_drv | output | 1 | Output drive enable for dq_o |

## Verification
The bench builds the block with ADDR_W=6 and WAKE_CYC=2. At 64 words the bench can prefill every address and keep its own model of the whole array. That puts deselected and discarded writes in reach, since a later read of any address checks them. A wake window of two cycles lets one run show both a discarded write and a served read inside the window, then an accepted write right after it. The six-bit address keeps both burst orders, with the base in mid-group, inside a small address range.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    // One command slot travelling down the pipeline
    typedef struct packed {
        logic   vld;
        logic   wr;
        lanes_t lanes;
    } op_t;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input order_e     ord);
        return (ord == ORD_XOR) ? (start ^ step) : (start + step);
    endfunction

    function automatic word_t lane_merge(input word_t  base,
                                         input word_t  fresh,
                                         input lanes_t take);
        word_t r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (take[i]) r[i*LANE_W +: LANE_W] = fresh[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/psram_burst.sv
module psram_burst
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              ld_n,
    input  logic              sel,
    input  logic              we_n,
    input  lanes_t            lane_we_n,
    input  logic              burst_il,
    input  logic [ADDR_W-1:0] addr,
    input  logic              no_op,
    input  logic              no_wr,
    output op_t               op,
    output logic [ADDR_W-1:0] op_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic              dir_q;
    logic              act_q;
    logic [1:0]        nxt_cnt;
    logic              load;
    logic              raw_vld;
    logic              raw_wr;

    assign load    = ~ld_n;
    assign nxt_cnt = cnt_q + 2'd1;

    always_comb begin
        if (load) begin
            op_addr = addr;
            raw_vld = sel;
            raw_wr  = ~we_n;
        end else begin
            op_addr = {base_q[ADDR_W-1:2],
                       burst_low(base_q[1:0], nxt_cnt, order_e'(burst_il))};
            raw_vld = act_q;
            raw_wr  = dir_q;
        end
        op.vld   = raw_vld & ~no_op & ~(raw_wr & no_wr);
        op.wr    = raw_wr;
        op.lanes = ~lane_we_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            act_q  <= 1'b0;
        end else if (adv) begin
            if (load) begin
                base_q <= addr;
                cnt_q  <= '0;
                dir_q  <= ~we_n;
                act_q  <= sel;
            end else begin
                cnt_q  <= nxt_cnt;
            end
        end
    end

    // R8: every continue cycle moves the beat count forward by exactly one
    p_burst_step_r8: assert property (@(posedge clk) disable iff (rst)
        (adv && ld_n) |=> ((cnt_q - $past(cnt_q)) == 2'd1));

    // R8: a load restarts the beat count and takes the new base
    p_burst_load_r8: assert property (@(posedge clk) disable iff (rst)
        (adv && !ld_n) |=> (cnt_q == 2'd0 && base_q == $past(addr)));

endmodule

// File: rtl/psram_array.sv
module psram_array
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  lanes_t            wr_lanes,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic hit;
    assign hit = wr_go && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_go && wr_lanes[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Same-edge write to the address being read: forward the lane (R4)
        assign rd_word[g*LANE_W +: LANE_W] =
            (hit && wr_lanes[g]) ? wr_data[g*LANE_W +: LANE_W] : bank[rd_addr];

        // R3: a selected lane holds exactly the data written to it
        p_lane_store_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_go && wr_lanes[g]) |=>
                (bank[$past(wr_addr)] == $past(wr_data[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import psram_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WAKE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              chip_en1_n,
    input  logic              chip_en2,
    input  logic              chip_en3_n,
    input  logic              we_n,
    input  logic [3:0]        lane_we_n,
    input  logic              ld_n,
    input  logic              burst_il,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic [35:0]       dq_i,
    output logic [35:0]       dq_o,
    output logic              dq_drv
);

    localparam int WAKE_W = $clog2(WAKE_CYC + 1);

    logic [WAKE_W-1:0] wake_q;
    logic              sel;
    op_t               op;
    logic [ADDR_W-1:0] op_addr;
    op_t               s1_q, s2_q;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    word_t             rd_word;
    logic              out_vld;
    logic              wr_go;

    assign sel = ~chip_en1_n & chip_en2 & ~chip_en3_n;

    // Recovery window after sleep
    always_ff @(posedge clk) begin
        if (rst)                          wake_q <= '0;
        else if (sleep)                   wake_q <= WAKE_W'(WAKE_CYC);
        else if (clk_en && wake_q != '0)  wake_q <= wake_q - WAKE_W'(1);
    end

    psram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .adv       (clk_en),
        .ld_n      (ld_n),
        .sel       (sel),
        .we_n      (we_n),
        .lane_we_n (lane_we_n),
        .burst_il  (burst_il),
        .addr      (addr),
        .no_op     (sleep),
        .no_wr     (wake_q != '0),
        .op        (op),
        .op_addr   (op_addr)
    );

    // Two-stage command pipeline; stage 2 meets the late write data
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= '0;
            s2_q    <= '0;
            s1_addr <= '0;
            s2_addr <= '0;
        end else if (clk_en) begin
            s1_q    <= op;
            s1_addr <= op_addr;
            s2_q    <= s1_q;
            s2_addr <= s1_addr;
        end
    end

    assign wr_go = clk_en && s2_q.vld && s2_q.wr;

    psram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (wr_go),
        .wr_addr  (s2_addr),
        .wr_lanes (s2_q.lanes),
        .wr_data  (dq_i),
        .rd_addr  (s1_addr),
        .rd_word  (rd_word)
    );

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            dq_o    <= '0;
        end else if (clk_en) begin
            out_vld <= s1_q.vld && !s1_q.wr && !sleep;
            if (s1_q.vld && !s1_q.wr) dq_o <= rd_word;
        end
    end

    assign dq_drv = out_vld && !oe_n && !sleep;

    // R5: no drive in the cycle carrying write data
    p_wr_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s1_q.vld && s1_q.wr) |=> !dq_drv);

    // R5: output enable high forces the output off
    p_oe_off_r5: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_drv);

    // R6: a stalled edge leaves the read port untouched
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(dq_o) && $stable(s2_addr) && $stable(s1_q)));

    // R9: sleeping device never drives
    p_sleep_off_r9: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_drv);

    // R10: no write enters the pipeline inside the recovery window
    p_wake_nowr_r10: assert property (@(posedge clk) disable iff (rst)
        (wake_q != '0) |-> !(op.vld && op.wr));

endmodule

// File: tb/sim_pipe_sram.sv
module sim_pipe_sram;

    localparam int AW = 6;
    localparam logic [2:0] CE_ON  = 3'b010;  // {chip_en1_n, chip_en2, chip_en3_n}
    localparam logic [2:0] CE_OFF = 3'b000;

    logic        clk = 1'b0;
    logic        rst;
    logic        clk_en;
    logic        chip_en1_n, chip_en2, chip_en3_n;
    logic        we_n;
    logic [3:0]  lane_we_n;
    logic        ld_n;
    logic        burst_il;
    logic [AW-1:0] addr;
    logic        sleep;
    logic        oe_n;
    logic [35:0] dq_i;
    logic [35:0] dq_o;
    logic        dq_drv;

    always #4 clk = ~clk;

    pipe_sram #(.ADDR_W(AW), .WAKE_CYC(2)) u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en),
        .chip_en1_n(chip_en1_n), .chip_en2(chip_en2), .chip_en3_n(chip_en3_n),
        .we_n(we_n), .lane_we_n(lane_we_n), .ld_n(ld_n), .burst_il(burst_il),
        .addr(addr), .sleep(sleep), .oe_n(oe_n), .dq_i(dq_i),
        .dq_o(dq_o), .dq_drv(dq_drv)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [35:0] model [64];

    // History of the two most recent enabled ops: 0 none, 1 read, 2 write, 3 expect no drive
    int          h_kind  [2];
    logic [AW-1:0] h_addr [2];
    logic [3:0]  h_lanes [2];
    logic [35:0] h_data  [2];
    string       h_tag   [2];

    // {wr, lane_we_n, addr, data}
    localparam logic [46:0] TBL [14] = '{
        {1'b1, 4'b0000, 6'd5, 36'h1_2345_6789},
        {1'b0, 4'b1111, 6'd5, 36'h0},
        {1'b1, 4'b1010, 6'd5, 36'hA_BCDE_F012},
        {1'b0, 4'b1111, 6'd5, 36'h0},
        {1'b0, 4'b1111, 6'd7, 36'h0},
        {1'b1, 4'b0111, 6'd7, 36'hF_0F0F_0F0F},
        {1'b1, 4'b0000, 6'd8, 36'h5_5555_5555},
        {1'b0, 4'b1111, 6'd7, 36'h0},
        {1'b0, 4'b1111, 6'd8, 36'h0},
        {1'b1, 4'b0000, 6'd9, 36'h3_C3C3_C3C3},
        {1'b0, 4'b1111, 6'd9, 36'h0},
        {1'b1, 4'b1110, 6'd9, 36'h6_9696_9696},
        {1'b0, 4'b1111, 6'd9, 36'h0},
        {1'b0, 4'b1111, 6'd5, 36'h0}
    };

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] fill(input logic [5:0] a);
        return {a, ~a, 6'h15, a, 6'h2a, ~a};
    endfunction

    // One enabled cycle: settle the op issued two cycles ago, then drive a new one
    task automatic step(input logic [2:0] ce, input logic sl, input logic ldn, input logic wr,
                        input logic [AW-1:0] a, input logic [3:0] lnn, input logic [35:0] d,
                        input int kind, input logic [AW-1:0] ea, input string tag);
        @(negedge clk);
        case (h_kind[1])
            1: chk(dq_drv === 1'b1 && dq_o === model[h_addr[1]], h_tag[1],
                   dq_drv ? dq_o : 36'hx, model[h_addr[1]]);
            2: begin
                dq_i = h_data[1];
                for (int i = 0; i < 4; i++)
                    if (!h_lanes[1][i]) model[h_addr[1]][i*9 +: 9] = h_data[1][i*9 +: 9];
            end
            3: chk(dq_drv === 1'b0, h_tag[1], {35'b0, dq_drv}, 36'h0);
            default: ;
        endcase
        clk_en     = 1'b1;
        chip_en1_n = ce[2];
        chip_en2   = ce[1];
        chip_en3_n = ce[0];
        sleep      = sl;
        ld_n       = ldn;
        we_n       = ~wr;
        addr       = a;
        lane_we_n  = lnn;
        h_kind[1]  = h_kind[0];
        h_addr[1]  = h_addr[0];
        h_lanes[1] = h_lanes[0];
        h_data[1]  = h_data[0];
        h_tag[1]   = h_tag[0];
        h_kind[0]  = kind;
        h_addr[0]  = ea;
        h_lanes[0] = lnn;
        h_data[0]  = d;
        h_tag[0]   = tag;
    endtask

    task automatic idle();
        step(CE_OFF, 1'b0, 1'b0, 1'b0, '0, 4'hF, '0, 3, '0, "R7 deselect idle");
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(CE_ON, 1'b0, 1'b0, 1'b0, a, 4'hF, '0, 1, a, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [35:0] held;
        for (int i = 0; i < 2; i++) begin
            h_kind[i] = 0; h_addr[i] = '0; h_lanes[i] = 4'hF; h_data[i] = '0; h_tag[i] = "";
        end
        rst = 1'b1; clk_en = 1'b1; chip_en1_n = 1'b1; chip_en2 = 1'b0; chip_en3_n = 1'b1;
        we_n = 1'b1; lane_we_n = 4'hF; ld_n = 1'b0; burst_il = 1'b0; addr = '0;
        sleep = 1'b0; oe_n = 1'b0; dq_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(dq_drv === 1'b0, "R11 reset no drive", {35'b0, dq_drv}, 36'h0);
        rst = 1'b0;

        // Prefill every word with back-to-back writes (R2)
        for (int a = 0; a < 64; a++)
            step(CE_ON, 1'b0, 1'b0, 1'b1, AW'(a), 4'h0, fill(6'(a)), 2, AW'(a), "R2 prefill");
        idle(); idle();
        for (int a = 0; a < 64; a += 9) rd(AW'(a), "R1 R2 prefill readback");

        // Table walk: alternating traffic, lane masks, same-address bypass
        for (int i = 0; i < 14; i++) begin
            logic [46:0] e;
            e = TBL[i];
            step(CE_ON, 1'b0, 1'b0, e[46], e[41:36], e[45:42], e[35:0],
                 e[46] ? 2 : 1, e[41:36], "R1 R2 R3 R4 table");
        end
        idle(); idle();

        // R5: asynchronous output enable
        oe_n = 1'b1;
        step(CE_ON, 1'b0, 1'b0, 1'b0, 6'd5, 4'hF, '0, 3, 6'd5, "R5 oe_n high");
        idle(); idle();
        oe_n = 1'b0;
        #1;
        chk(dq_drv === 1'b1 && dq_o === model[5], "R5 oe_n release", dq_o, model[5]);

        // R7: each chip select alone deselects a write
        step(3'b110, 1'b0, 1'b0, 1'b1, 6'd10, 4'h0, 36'hF_FFFF_FFFF, 3, 6'd10, "R7 en1 off");
        step(3'b000, 1'b0, 1'b0, 1'b1, 6'd11, 4'h0, 36'hF_FFFF_FFFF, 3, 6'd11, "R7 en2 off");
        step(3'b011, 1'b0, 1'b0, 1'b1, 6'd12, 4'h0, 36'hF_FFFF_FFFF, 3, 6'd12, "R7 en3 off");
        rd(6'd10, "R7 word 10 kept"); rd(6'd11, "R7 word 11 kept"); rd(6'd12, "R7 word 12 kept");
        idle(); idle();

        // R8: linear burst read from base 13 (low bits 01): 13,14,15,12
        burst_il = 1'b0;
        rd(6'd13, "R8 linear load");
        step(CE_ON, 1'b0, 1'b1, 1'b1, 6'h3F, 4'hF, '0, 1, 6'd14, "R8 linear beat1");
        step(CE_ON, 1'b0, 1'b1, 1'b1, 6'h3F, 4'hF, '0, 1, 6'd15, "R8 linear beat2");
        step(CE_ON, 1'b0, 1'b1, 1'b1, 6'h3F, 4'hF, '0, 1, 6'd12, "R8 linear beat3");
        idle(); idle();
        // XOR order from base 13: 13,12,15,14
        burst_il = 1'b1;
        rd(6'd13, "R8 xor load");
        step(CE_ON, 1'b0, 1'b1, 1'b0, 6'h00, 4'hF, '0, 1, 6'd12, "R8 xor beat1");
        step(CE_ON, 1'b0, 1'b1, 1'b0, 6'h00, 4'hF, '0, 1, 6'd15, "R8 xor beat2");
        step(CE_ON, 1'b0, 1'b1, 1'b0, 6'h00, 4'hF, '0, 1, 6'd14, "R8 xor beat3");
        idle(); idle();
        // Burst write, linear from 20, direction kept from load
        burst_il = 1'b0;
        step(CE_ON, 1'b0, 1'b0, 1'b1, 6'd20, 4'h0, 36'h1_1111_1111, 2, 6'd20, "R8 burst wr load");
        step(CE_ON, 1'b0, 1'b1, 1'b0, 6'h3F, 4'h0, 36'h2_2222_2222, 2, 6'd21, "R8 burst wr beat1");
        step(CE_ON, 1'b0, 1'b1, 1'b0, 6'h3F, 4'h0, 36'h3_3333_3333, 2, 6'd22, "R8 burst wr beat2");
        step(CE_ON, 1'b0, 1'b1, 1'b0, 6'h3F, 4'h0, 36'h4_4444_4444, 2, 6'd23, "R8 burst wr beat3");
        for (int a = 20; a < 24; a++) rd(AW'(a), "R8 burst wr readback");
        idle(); idle();

        // R6: clock-enable stall
        rd(6'd29, "R6 read before stall");
        rd(6'd30, "R6 read across stall");
        @(negedge clk);
        held = dq_o;
        chk(dq_drv === 1'b1 && dq_o === model[29], "R1 R6 output at stall", dq_o, model[29]);
        clk_en = 1'b0;
        we_n = 1'b0; ld_n = 1'b0; addr = 6'd30; lane_we_n = 4'h0;
        repeat (3) begin
            @(negedge clk);
            chk(dq_drv === 1'b1 && dq_o === held, "R6 output held", dq_o, held);
        end
        idle(); idle(); idle();
        rd(6'd30, "R6 stalled write ignored");
        idle(); idle();

        // R9 / R10: sleep then recovery window
        step(CE_ON, 1'b1, 1'b0, 1'b0, 6'd31, 4'hF, '0, 3, 6'd31, "R9 sleep read");
        step(CE_ON, 1'b1, 1'b0, 1'b1, 6'd31, 4'h0, '0, 3, 6'd31, "R9 sleep write");
        step(CE_ON, 1'b1, 1'b0, 1'b0, 6'd31, 4'hF, '0, 3, 6'd31, "R9 sleep read");
        step(CE_ON, 1'b0, 1'b0, 1'b1, 6'd31, 4'h0, 36'hE_EEEE_EEEE, 3, 6'd31, "R10 wake write dropped");
        rd(6'd33, "R10 wake read served");
        step(CE_ON, 1'b0, 1'b0, 1'b1, 6'd32, 4'h0, 36'h7_7777_0000, 2, 6'd32, "R10 write after window");
        rd(6'd32, "R10 write after window");
        rd(6'd31, "R10 dropped write absent");
        idle(); idle(); idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule